// File: doc/BRIEF.md
# Dual-Side Mailbox Register File

This block is a register bank shared by two bus agents: a host side and a management-controller side. Each side has a plain register port with a write strobe, an address, write data and combinational read data. The two sides see one common set of sixteen byte-wide data registers. By convention the messaging scheme places a command byte at 0, a sequence number at 1, arguments at 2 to 12, a response code at 13, a host-owned status byte at 14 and a controller-owned status byte at 15. The bank gives these bytes no meaning.

Each side also has private configuration bytes: a control register, two write-interrupt enable bytes, two write-interrupt mask bytes and two write-pending bytes. A side rings the other side's doorbell through its own control register. The doorbell sets a pending flag that the receiver can poll. The receiver can also ask for an interrupt whenever the other side writes selected data registers. Each side has one interrupt output that combines all of its unmasked sources.

Address map on each side: 0 to 15 are the data registers, 16 is control, 17 and 18 are enables, 19 and 20 are masks, 21 and 22 are pending, and 23 to 31 are unmapped. Writes take effect at the clock edge and reads are combinational.

Top module: `mbx_bank`

## Requirements
- R1: After synchronous reset every data and configuration byte reads 0x00 on both sides, and both interrupt outputs are low.
- R2: A write to data address 0..15 from either side can be read back at the same address from both sides on the following cycle.
- R3: When both sides write the same data register in the same cycle, the controller-side value is stored.
- R4: Writing address 16 with bit 0 set rings the doorbell, which sets bit 7 of the other side's control register on the next cycle. Bit 0 is a trigger and always reads 0.
- R5: Writing address 16 with bit 7 set clears the side's own doorbell pending bit 7. If the other side rings in the same cycle, the pending bit stays set.
- R6: Control bit 1 is a doorbell mask. While it is 1, a pending doorbell stays readable in bit 7 but does not drive the side's interrupt.
- R7: Enable bytes sit at 17 (bit i stands for data register i, i = 0..7) and 18 (bit i stands for register 8+i). When enable bit n is set, a write by the other side to data register n sets write-pending bit n. A side's own writes never set its own pending bits.
- R8: Mask bytes sit at 19 and 20, with the same bit mapping as the enable bytes. A set mask bit stops the matching pending bit from driving the interrupt, but the pending bit stays readable.
- R9: Write-pending bytes sit at 21 and 22, with the same bit mapping. Pending bits are sticky and are cleared by writing 1 to them. A new write event in the same cycle as a clear leaves the bit set.
- R10: Each interrupt output is the OR of the unmasked doorbell and the unmasked write-pending bits. Addresses 23..31 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Host-side write strobe |
| h_addr | input | 5 | Host-side register address |
| h_wdata | input | 8 | Host-side write data |
| h_rdata | output | 8 | Host-side read data (combinational) |
| c_we | input | 1 | Controller-side write strobe |
| c_addr | input | 5 | Controller-side register address |
| c_wdata | input | 8 | Controller-side write data |
| c_rdata | output | 8 | Controller-side read data (combinational) |
| h_irq | output | 1 | Interrupt toward the host |
| c_irq | output | 1 | Interrupt toward the controller |

## Verification
Two pairs of functions can fall into the same cycle. In the first pair, one side rings or writes an enabled data register while the other side clears the matching doorbell or pending bit. In the second pair, both sides write one data register together. The bench drives both ports in the same cycle to produce each case. It then judges the result from read-back values and the interrupt pins: the pending bit must survive the clear, and the controller's data byte must be the one stored.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NREG      = 16;
    localparam int DW        = 8;
    localparam int NBYTE     = NREG / DW;
    localparam int ADDR_CTRL = NREG;
    localparam int ADDR_EN   = ADDR_CTRL + 1;
    localparam int ADDR_MASK = ADDR_EN + NBYTE;
    localparam int ADDR_PEND = ADDR_MASK + NBYTE;
    localparam int NADDR     = ADDR_PEND + NBYTE;
    localparam int AW        = $clog2(NADDR);
    localparam int IW        = $clog2(NREG);

    localparam int CTRL_RING   = 0;
    localparam int CTRL_DBMASK = 1;
    localparam int CTRL_PEND   = 7;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } acc_t;

    function automatic logic is_data(input logic [AW-1:0] a);
        return a < AW'(NREG);
    endfunction
endpackage

// File: rtl/mbx_data.sv
module mbx_data
    import mbx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  acc_t                 h_acc,
    input  acc_t                 c_acc,
    output logic [NREG*DW-1:0]   data_q,
    output logic [NREG-1:0]      h_hit,
    output logic [NREG-1:0]      c_hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_comb begin
            h_hit[i] = h_acc.we && (h_acc.addr == AW'(i));
            c_hit[i] = c_acc.we && (c_acc.addr == AW'(i));
        end

        always_ff @(posedge clk) begin
            if (rst)
                data_q[i*DW +: DW] <= '0;
            else if (c_hit[i])
                data_q[i*DW +: DW] <= c_acc.wdata;
            else if (h_hit[i])
                data_q[i*DW +: DW] <= h_acc.wdata;
        end
    end
endmodule

// File: rtl/mbx_side.sv
module mbx_side
    import mbx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  acc_t            own,
    input  logic            peer_ring,
    input  logic [NREG-1:0] peer_hit,
    output logic            ring,
    output logic            db_pend,
    output logic [NREG-1:0] pend_q,
    output logic [DW-1:0]   cfg_rdata,
    output logic            irq
);
    logic            db_mask;
    logic [NREG-1:0] en_q;
    logic [NREG-1:0] mask_q;
    logic            ctrl_wr;

    assign ctrl_wr = own.we && (own.addr == AW'(ADDR_CTRL));
    assign ring    = ctrl_wr && own.wdata[CTRL_RING];

    always_ff @(posedge clk) begin
        if (rst) begin
            db_pend <= 1'b0;
            db_mask <= 1'b0;
        end else begin
            if (ctrl_wr)
                db_mask <= own.wdata[CTRL_DBMASK];
            if (peer_ring)
                db_pend <= 1'b1;
            else if (ctrl_wr && own.wdata[CTRL_PEND])
                db_pend <= 1'b0;
        end
    end

    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        logic en_wr, mask_wr, pend_wr;
        logic [DW-1:0] clr;

        always_comb begin
            en_wr   = own.we && (own.addr == AW'(ADDR_EN + k));
            mask_wr = own.we && (own.addr == AW'(ADDR_MASK + k));
            pend_wr = own.we && (own.addr == AW'(ADDR_PEND + k));
            clr     = pend_wr ? own.wdata : '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[k*DW +: DW]   <= '0;
                mask_q[k*DW +: DW] <= '0;
                pend_q[k*DW +: DW] <= '0;
            end else begin
                if (en_wr)
                    en_q[k*DW +: DW] <= own.wdata;
                if (mask_wr)
                    mask_q[k*DW +: DW] <= own.wdata;
                pend_q[k*DW +: DW] <= (pend_q[k*DW +: DW] & ~clr)
                                    | (peer_hit[k*DW +: DW] & en_q[k*DW +: DW]);
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (own.addr == AW'(ADDR_CTRL)) begin
            cfg_rdata[CTRL_PEND]   = db_pend;
            cfg_rdata[CTRL_DBMASK] = db_mask;
        end
        for (int k = 0; k < NBYTE; k++) begin
            if (own.addr == AW'(ADDR_EN + k))   cfg_rdata = en_q[k*DW +: DW];
            if (own.addr == AW'(ADDR_MASK + k)) cfg_rdata = mask_q[k*DW +: DW];
            if (own.addr == AW'(ADDR_PEND + k)) cfg_rdata = pend_q[k*DW +: DW];
        end
    end

    assign irq = (db_pend && !db_mask) || |(pend_q & ~mask_q);
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          c_we,
    input  logic [AW-1:0] c_addr,
    input  logic [DW-1:0] c_wdata,
    output logic [DW-1:0] c_rdata,
    output logic          h_irq,
    output logic          c_irq
);
    acc_t                h_acc, c_acc;
    logic [NREG*DW-1:0]  data_q;
    logic [NREG-1:0]     h_hit, c_hit;
    logic                h_ring, c_ring;
    logic                h_db_pend, c_db_pend;
    logic [NREG-1:0]     h_wpend, c_wpend;
    logic [DW-1:0]       h_cfg, c_cfg;

    assign h_acc = '{we: h_we, addr: h_addr, wdata: h_wdata};
    assign c_acc = '{we: c_we, addr: c_addr, wdata: c_wdata};

    mbx_data u_data (
        .clk    (clk),
        .rst    (rst),
        .h_acc  (h_acc),
        .c_acc  (c_acc),
        .data_q (data_q),
        .h_hit  (h_hit),
        .c_hit  (c_hit)
    );

    mbx_side u_hside (
        .clk       (clk),
        .rst       (rst),
        .own       (h_acc),
        .peer_ring (c_ring),
        .peer_hit  (c_hit),
        .ring      (h_ring),
        .db_pend   (h_db_pend),
        .pend_q    (h_wpend),
        .cfg_rdata (h_cfg),
        .irq       (h_irq)
    );

    mbx_side u_cside (
        .clk       (clk),
        .rst       (rst),
        .own       (c_acc),
        .peer_ring (h_ring),
        .peer_hit  (h_hit),
        .ring      (c_ring),
        .db_pend   (c_db_pend),
        .pend_q    (c_wpend),
        .cfg_rdata (c_cfg),
        .irq       (c_irq)
    );

    assign h_rdata = is_data(h_addr) ? data_q[DW*int'(h_addr[IW-1:0]) +: DW] : h_cfg;
    assign c_rdata = is_data(c_addr) ? data_q[DW*int'(c_addr[IW-1:0]) +: DW] : c_cfg;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
    import mbx_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            h_we,
    input logic [AW-1:0]   h_addr,
    input logic [DW-1:0]   h_wdata,
    input logic            c_we,
    input logic [AW-1:0]   c_addr,
    input logic [DW-1:0]   c_wdata,
    input logic            h_irq,
    input logic            c_irq,
    input logic            h_db_pend,
    input logic            c_db_pend,
    input logic [NREG-1:0] h_wpend,
    input logic [NREG-1:0] c_wpend
);
    logic h_rings, c_rings;
    assign h_rings = h_we && h_addr == AW'(ADDR_CTRL) && h_wdata[CTRL_RING];
    assign c_rings = c_we && c_addr == AW'(ADDR_CTRL) && c_wdata[CTRL_RING];

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!h_irq && !c_irq));

    // R4
    host_ring_chk: assert property (@(posedge clk) disable iff (rst)
        h_rings |=> c_db_pend);

    // R4
    ctrl_ring_chk: assert property (@(posedge clk) disable iff (rst)
        c_rings |=> h_db_pend);

    // R5
    db_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (c_we && c_addr == AW'(ADDR_CTRL) && c_wdata[CTRL_PEND] && !h_rings) |=> !c_db_pend);

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        c_irq |-> (c_db_pend || c_wpend != '0));

    // R10
    hirq_source_chk: assert property (@(posedge clk) disable iff (rst)
        h_irq |-> (h_db_pend || h_wpend != '0));
endmodule

bind mbx_bank mbx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .h_we      (h_we),
    .h_addr    (h_addr),
    .h_wdata   (h_wdata),
    .c_we      (c_we),
    .c_addr    (c_addr),
    .c_wdata   (c_wdata),
    .h_irq     (h_irq),
    .c_irq     (c_irq),
    .h_db_pend (h_db_pend),
    .c_db_pend (c_db_pend),
    .h_wpend   (h_wpend),
    .c_wpend   (c_wpend)
);

// File: tb/mbx_bank_tb.sv
module mbx_bank_tb;
    import mbx_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          h_we = 1'b0, c_we = 1'b0;
    logic [AW-1:0] h_addr = '0, c_addr = '0;
    logic [DW-1:0] h_wdata = '0, c_wdata = '0;
    logic [DW-1:0] h_rdata, c_rdata;
    logic          h_irq, c_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mbx_bank u_dut (
        .clk(clk), .rst(rst),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .h_irq(h_irq), .c_irq(c_irq)
    );

    // entry: {req, wside, waddr, wdata, rside, raddr, expected}; side 0 = host, 1 = controller
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {4'd2,  1'b0, 5'd0,  8'hA5, 1'b1, 5'd0,  8'hA5},  // R2 host -> ctrl view
        {4'd2,  1'b1, 5'd15, 8'h3C, 1'b0, 5'd15, 8'h3C},  // R2 ctrl -> host view
        {4'd7,  1'b1, 5'd17, 8'h02, 1'b1, 5'd17, 8'h02},  // R7 enable reg 1 for ctrl
        {4'd7,  1'b0, 5'd1,  8'h11, 1'b1, 5'd21, 8'h02},  // R7 enabled write sets pending
        {4'd7,  1'b0, 5'd2,  8'h22, 1'b1, 5'd21, 8'h02},  // R7 disabled reg leaves pending
        {4'd7,  1'b1, 5'd1,  8'h99, 1'b1, 5'd21, 8'h02},  // R7 own write no own pending
        {4'd9,  1'b1, 5'd21, 8'h02, 1'b1, 5'd21, 8'h00},  // R9 write-one clear
        {4'd8,  1'b0, 5'd20, 8'h80, 1'b0, 5'd20, 8'h80},  // R8 mask readback
        {4'd10, 1'b0, 5'd25, 8'hFF, 1'b0, 5'd25, 8'h00},  // R10 unmapped
        {4'd4,  1'b0, 5'd16, 8'h01, 1'b1, 5'd16, 8'h80},  // R4 doorbell to ctrl
        {4'd4,  1'b0, 5'd16, 8'h00, 1'b0, 5'd16, 8'h00},  // R4 trigger reads zero
        {4'd5,  1'b1, 5'd16, 8'h80, 1'b1, 5'd16, 8'h00}   // R5 clear doorbell
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr2(input logic hw, input logic [AW-1:0] ha, input logic [7:0] hd,
                       input logic cw, input logic [AW-1:0] ca, input logic [7:0] cd);
        @(negedge clk);
        h_we = hw; h_addr = ha; h_wdata = hd;
        c_we = cw; c_addr = ca; c_wdata = cd;
        @(negedge clk);
        h_we = 1'b0; c_we = 1'b0;
    endtask

    task automatic hwr(input logic [AW-1:0] a, input logic [7:0] d);
        wr2(1'b1, a, d, 1'b0, '0, '0);
    endtask

    task automatic cwr(input logic [AW-1:0] a, input logic [7:0] d);
        wr2(1'b0, '0, '0, 1'b1, a, d);
    endtask

    task automatic rd(input logic side, input logic [AW-1:0] a, output logic [7:0] d);
        if (side) c_addr = a; else h_addr = a;
        #1;
        d = side ? c_rdata : h_rdata;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 h_irq", {7'd0, h_irq}, 8'h00);
        check("R1 c_irq", {7'd0, c_irq}, 8'h00);
        rd(1'b0, 5'd0, v);  check("R1 data0", v, 8'h00);
        rd(1'b1, 5'd16, v); check("R1 ctrl", v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] e;
            string m;
            e = VEC[i];
            if (e[27]) cwr(e[26:22], e[21:14]); else hwr(e[26:22], e[21:14]);
            rd(e[13], e[12:8], v);
            m = $sformatf("R%0d vec%0d", e[31:28], i);
            check(m, v, e[7:0]);
        end

        // R3 same-register collision
        wr2(1'b1, 5'd5, 8'h55, 1'b1, 5'd5, 8'hCC);
        rd(1'b0, 5'd5, v); check("R3 ctrl wins", v, 8'hCC);

        // R6 doorbell mask
        cwr(5'd16, 8'h02);
        hwr(5'd16, 8'h01);
        rd(1'b1, 5'd16, v); check("R6 masked pend", v, 8'h82);
        check("R6 irq masked", {7'd0, c_irq}, 8'h00);
        cwr(5'd16, 8'h00);
        check("R6 irq unmasked", {7'd0, c_irq}, 8'h01);
        cwr(5'd16, 8'h80);
        check("R5 irq cleared", {7'd0, c_irq}, 8'h00);

        // R5 ring and clear in one cycle
        wr2(1'b1, 5'd16, 8'h01, 1'b1, 5'd16, 8'h80);
        rd(1'b1, 5'd16, v); check("R5 set beats clear", v, 8'h80);
        cwr(5'd16, 8'h80);
        rd(1'b1, 5'd16, v); check("R5 cleared", v, 8'h00);

        // R8 mask keeps pending readable
        hwr(5'd18, 8'h80);
        cwr(5'd15, 8'h01);
        rd(1'b0, 5'd22, v); check("R8 pending visible", v, 8'h80);
        check("R8 irq masked", {7'd0, h_irq}, 8'h00);
        hwr(5'd20, 8'h00);
        check("R10 irq from pending", {7'd0, h_irq}, 8'h01);
        hwr(5'd22, 8'h80);
        check("R9 h clear irq", {7'd0, h_irq}, 8'h00);

        // R9 event and clear in one cycle
        wr2(1'b1, 5'd1, 8'h77, 1'b1, 5'd21, 8'h02);
        rd(1'b1, 5'd21, v); check("R9 set beats clear", v, 8'h02);
        check("R9 irq", {7'd0, c_irq}, 8'h01);
        rd(1'b1, 5'd1, v); check("R2 data1", v, 8'h77);
        cwr(5'd21, 8'h02);
        check("R9 cleared", {7'd0, c_irq}, 8'h00);

        // R10 OR of both sources
        hwr(5'd16, 8'h01);
        hwr(5'd1, 8'h10);
        cwr(5'd16, 8'h80);
        check("R10 pending keeps irq", {7'd0, c_irq}, 8'h01);
        cwr(5'd21, 8'h02);
        check("R10 all clear", {7'd0, c_irq}, 8'h00);

        // R1 reset again
        hwr(5'd16, 8'h01);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(1'b0, 5'd0, v);  check("R1 data after reset", v, 8'h00);
        rd(1'b1, 5'd17, v); check("R1 enable after reset", v, 8'h00);
        check("R1 c_irq after reset", {7'd0, c_irq}, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule